// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block turns the two phase-shifted square waves of an incremental encoder into a position count. Both channels are first brought into the clock domain. Edges are then found by comparing each synchronised sample with the one before it. Each edge that counts moves an up/down counter by one step, and the direction of that step comes from the level of the opposite channel.

A 4-bit mode input selects which edges count:
- edges of channel A only,
- edges of channel B only, or
- edges of both channels, which gives four counts per encoder cycle.

A programmable reload value sets the top of the counting range. Counting up past it returns the counter to zero. Counting down from zero loads the reload value. A direction output shows whether the last counted step went up or down.

All configuration arrives on plain input ports. The enable input freezes the count while it is low.

Top module: `quad_pos_counter`

## Requirements
- R1: While reset is asserted, and right after it is released, `count` is 0 and `dir_down` is 0.
- R2: With `mode` = 4'b0011, an edge on either channel counts. An edge on A counts up when the new A level differs from B, and down otherwise. An edge on B counts up when the new B level equals A, and down otherwise. The sequence AB = 00,10,11,01,00 therefore advances the count by four.
- R3: With `mode` = 4'b0001, only edges of A count, using the A rule of R2. Edges of B leave the count unchanged.
- R4: With `mode` = 4'b0010, only edges of B count, using the B rule of R2. Edges of A leave the count unchanged.
- R5: An up step taken when `count` is greater than or equal to `reload` sets `count` to 0.
- R6: A down step taken when `count` is 0 loads `count` with `reload`.
- R7: `dir_down` becomes 0 on every counted up step and 1 on every counted down step. At all other times it holds its value.
- R8: While `en` is 0, `count` and `dir_down` hold their values.
- R9: When both synchronised channels change in the same sample, the transition is treated as invalid and nothing changes.
- R10: Any `mode` value other than 4'b0001, 4'b0010 and 4'b0011 counts nothing.
- R11: A channel change set up before a rising clock edge appears on `count` after the third rising edge counted from that one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Count enable |
| mode | input | 4 | Encoder mode select |
| reload | input | CNT_W | Top of counting range |
| ch_a | input | 1 | Encoder channel A, asynchronous |
| ch_b | input | 1 | Encoder channel B, asynchronous |
| count | output | CNT_W | Current position count |
| dir_down | output | 1 | Direction of last counted step, 1 = down |

## Verification
The bench builds the block with CNT_W = 16. At this width the all-ones reload value stays directly reachable: a single down step from zero lands on 0xFFFF, and a single up step from there wraps back to zero. The same steps, run with a small reload value and with a reload lowered below the current count, reach both wrap rules within a handful of encoder transitions.

// File: rtl/quad_pos_counter.sv
module quad_pos_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [3:0]       mode,
  input  logic [CNT_W-1:0] reload,
  input  logic             ch_a,
  input  logic             ch_b,
  output logic [CNT_W-1:0] count,
  output logic             dir_down
);
  localparam logic [3:0] M_A  = 4'b0001;
  localparam logic [3:0] M_B  = 4'b0010;
  localparam logic [3:0] M_AB = 4'b0011;
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [1:0] a_sync, b_sync;
  logic       a_prev, b_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_sync <= 2'b00;
      b_sync <= 2'b00;
      a_prev <= 1'b0;
      b_prev <= 1'b0;
    end else begin
      a_sync <= {a_sync[0], ch_a};
      b_sync <= {b_sync[0], ch_b};
      a_prev <= a_sync[1];
      b_prev <= b_sync[1];
    end
  end

  logic a_edge, b_edge, a_hit, b_hit, step, go_up;
  logic [CNT_W-1:0] up_val, dn_val;

  assign a_edge = a_sync[1] ^ a_prev;
  assign b_edge = b_sync[1] ^ b_prev;
  assign a_hit  = a_edge && !b_edge && (mode == M_A || mode == M_AB);
  assign b_hit  = b_edge && !a_edge && (mode == M_B || mode == M_AB);
  assign step   = en && (a_hit || b_hit);
  assign go_up  = a_hit ? (a_sync[1] != b_sync[1]) : (b_sync[1] == a_sync[1]);
  assign up_val = (count >= reload) ? '0 : count + ONE;
  assign dn_val = (count == '0) ? reload : count - ONE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count    <= '0;
      dir_down <= 1'b0;
    end else if (step) begin
      count    <= go_up ? up_val : dn_val;
      dir_down <= !go_up;
    end
  end
endmodule

module quad_pos_counter_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic [3:0]       mode,
  input logic [CNT_W-1:0] reload,
  input logic [CNT_W-1:0] count,
  input logic             dir_down,
  input logic             a_now,
  input logic             a_old,
  input logic             b_now,
  input logic             b_old
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  p_hold_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(count) && $stable(dir_down)));

  p_bad_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mode inside {4'b0001, 4'b0010, 4'b0011}) |=> $stable(count));

  p_pair_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((a_now != a_old) && (b_now != b_old)) |=> $stable(count));

  p_single_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(count) |-> (count == $past(count) + ONE || count == $past(count) - ONE
                         || count == '0 || count == $past(reload)));

  p_dir_with_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(dir_down) && $past(reload) != '0) |-> !$stable(count));
endmodule

bind quad_pos_counter quad_pos_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .reload(reload),
  .count(count), .dir_down(dir_down),
  .a_now(a_sync[1]), .a_old(a_prev), .b_now(b_sync[1]), .b_old(b_prev)
);

// File: tb/tb_quad_pos_counter.sv
module tb_quad_pos_counter;
  localparam int W = 16;
  localparam int N = 28;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [3:0] mode = 4'b0011;
  logic [W-1:0] reload = '1;
  logic ch_a = 1'b0, ch_b = 1'b0;
  logic [W-1:0] count;
  logic dir_down;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  quad_pos_counter #(.CNT_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .reload(reload),
    .ch_a(ch_a), .ch_b(ch_b), .count(count), .dir_down(dir_down)
  );

  // {req, mode, en, reload, a, b, exp_count, exp_dir}
  localparam logic [43:0] VEC [0:N-1] = '{
    {4'd2,  4'd3, 1'b1, 16'hFFFF, 1'b1, 1'b0, 16'd1,    1'b0}, // R2
    {4'd2,  4'd3, 1'b1, 16'hFFFF, 1'b1, 1'b1, 16'd2,    1'b0}, // R2
    {4'd2,  4'd3, 1'b1, 16'hFFFF, 1'b0, 1'b1, 16'd3,    1'b0}, // R2
    {4'd2,  4'd3, 1'b1, 16'hFFFF, 1'b0, 1'b0, 16'd4,    1'b0}, // R2
    {4'd7,  4'd3, 1'b1, 16'hFFFF, 1'b0, 1'b1, 16'd3,    1'b1}, // R7
    {4'd2,  4'd3, 1'b1, 16'hFFFF, 1'b1, 1'b1, 16'd2,    1'b1}, // R2
    {4'd2,  4'd3, 1'b1, 16'hFFFF, 1'b1, 1'b0, 16'd1,    1'b1}, // R2
    {4'd2,  4'd3, 1'b1, 16'hFFFF, 1'b0, 1'b0, 16'd0,    1'b1}, // R2
    {4'd6,  4'd3, 1'b1, 16'hFFFF, 1'b0, 1'b1, 16'hFFFF, 1'b1}, // R6
    {4'd5,  4'd3, 1'b1, 16'hFFFF, 1'b0, 1'b0, 16'd0,    1'b0}, // R5
    {4'd3,  4'd1, 1'b1, 16'hFFFF, 1'b1, 1'b0, 16'd1,    1'b0}, // R3
    {4'd3,  4'd1, 1'b1, 16'hFFFF, 1'b1, 1'b1, 16'd1,    1'b0}, // R3
    {4'd3,  4'd1, 1'b1, 16'hFFFF, 1'b0, 1'b1, 16'd2,    1'b0}, // R3
    {4'd3,  4'd1, 1'b1, 16'hFFFF, 1'b0, 1'b0, 16'd2,    1'b0}, // R3
    {4'd4,  4'd2, 1'b1, 16'hFFFF, 1'b1, 1'b0, 16'd2,    1'b0}, // R4
    {4'd4,  4'd2, 1'b1, 16'hFFFF, 1'b1, 1'b1, 16'd3,    1'b0}, // R4
    {4'd4,  4'd2, 1'b1, 16'hFFFF, 1'b0, 1'b1, 16'd3,    1'b0}, // R4
    {4'd4,  4'd2, 1'b1, 16'hFFFF, 1'b0, 1'b0, 16'd4,    1'b0}, // R4
    {4'd8,  4'd3, 1'b0, 16'hFFFF, 1'b1, 1'b0, 16'd4,    1'b0}, // R8
    {4'd8,  4'd3, 1'b0, 16'hFFFF, 1'b1, 1'b1, 16'd4,    1'b0}, // R8
    {4'd8,  4'd3, 1'b1, 16'hFFFF, 1'b0, 1'b1, 16'd5,    1'b0}, // R8
    {4'd5,  4'd3, 1'b1, 16'd6,    1'b0, 1'b0, 16'd6,    1'b0}, // R5
    {4'd5,  4'd3, 1'b1, 16'd6,    1'b1, 1'b0, 16'd0,    1'b0}, // R5
    {4'd6,  4'd3, 1'b1, 16'd6,    1'b0, 1'b0, 16'd6,    1'b1}, // R6
    {4'd9,  4'd3, 1'b1, 16'd6,    1'b1, 1'b1, 16'd6,    1'b1}, // R9
    {4'd10, 4'd4, 1'b1, 16'd6,    1'b0, 1'b1, 16'd6,    1'b1}, // R10
    {4'd10, 4'd0, 1'b1, 16'd6,    1'b0, 1'b0, 16'd6,    1'b1}, // R10
    {4'd5,  4'd3, 1'b1, 16'd3,    1'b1, 1'b0, 16'd0,    1'b0}  // R5 reload below count
  };

  task automatic check(input int req, input logic [W-1:0] ec, input logic ed);
    checks++;
    if (count !== ec || dir_down !== ed) begin
      fails++;
      $display("FAIL R%0d: count=%0h dir=%0b expected count=%0h dir=%0b", req, count, dir_down, ec, ed);
    end
  endtask

  initial begin
    #200000;
    fails++; checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(1, '0, 1'b0); // R1 during reset
    rst_n = 1'b1; en = 1'b1;
    @(negedge clk);
    check(1, '0, 1'b0); // R1 after release
    for (int i = 0; i < N; i++) begin
      {mode, en, reload, ch_a, ch_b} = VEC[i][39:17];
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(int'(VEC[i][43:40]), VEC[i][16:1], VEC[i][0]);
    end
    // R11: latency of exactly three rising edges (inputs now AB=10, count 0)
    mode = 4'd3; reload = '1; en = 1'b1;
    ch_a = 1'b1; ch_b = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check(11, '0, 1'b0);
    @(posedge clk); @(negedge clk);
    check(11, 16'd1, 1'b0);
    // R1: reset mid-run clears state
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(1, '0, 1'b0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule